// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls a port of general-purpose pins through a byte-wide register bus. Three registers are mapped: a read-only view of the synchronized pin levels, a direction mask and an output data latch. For each pin the block produces three pad controls: an output enable, an output value and a weak pull-up enable. The tri-state pad cell itself sits outside the block.

A pin with its direction bit set drives the value of its latch bit. A pin with its direction bit clear floats. Its latch bit then chooses whether the pull-up is on. A write of ones to the pin-view address inverts the matching latch bits in one bus cycle, so software needs no read-modify-write sequence to toggle pins. External levels pass through a multi-flop synchronizer before they can be read.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, the direction and latch registers are all zero, so pad_oe and pad_pu are zero and offsets 1 and 2 read zero.
- R2: A write strobe at offset 1 loads the direction register from bus_wdata on that clock edge. pad_oe bit n equals direction bit n, and a read at offset 1 returns the register.
- R3: A write strobe at offset 2 loads the output latch from bus_wdata on that clock edge. A read at offset 2 returns the latch contents, not the pin levels.
- R4: pad_out bit n always equals latch bit n. A pin whose direction bit is 1 is therefore driven high for latch 1 and low for latch 0.
- R5: pad_pu bit n is 1 exactly when direction bit n is 0 and latch bit n is 1. The pull-up is never enabled on an output pin.
- R6: A write strobe at offset 0 inverts each latch bit whose bus_wdata bit is 1 and leaves the other latch bits unchanged. It does not alter the direction register.
- R7: A read at offset 0 returns pin_in as sampled two rising clock edges earlier, whatever the direction bits are. Zero is returned until two edges after reset.
- R8: Offset 3 is unmapped. It reads as zero, and a write strobe there changes neither the direction register nor the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (2) | Register offset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | PIN_W (8) | Write data |
| bus_rdata | output | PIN_W (8) | Combinational read data for bus_addr |
| pin_in | input | PIN_W (8) | Raw external pin levels |
| pad_oe | output | PIN_W (8) | Per-pin output enable |
| pad_out | output | PIN_W (8) | Per-pin output value |
| pad_pu | output | PIN_W (8) | Per-pin pull-up enable |

## Verification
The bench builds the block with its defaults: eight pins, a two-bit offset and a two-stage synchronizer. With these values the unmapped offset 3 can be addressed, and the exact two-edge latency from pin_in to the offset-0 read can be checked. Directed writes set up mixed direction and latch patterns, toggles and unmapped writes. A long stretch of random bus and pin traffic then checks every output against the reference model on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   typedef enum logic [1:0] {
      SEL_PIN  = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_LAT  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[s] <= '0;
            else        st[s] <= st[s-1];
         end
      end
   end

   assign q_out = st[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  reg_sel_e     sel,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] lat_q
);
   logic [W-1:0] dir_d, lat_d;

   always_comb begin
      dir_d = dir_q;
      lat_d = lat_q;
      if (wr) begin
         unique case (sel)
            SEL_DIR:  dir_d = wdata;
            SEL_LAT:  lat_d = wdata;
            SEL_PIN:  lat_d = lat_q ^ wdata;
            SEL_NONE: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         lat_q <= '0;
      end else begin
         dir_q <= dir_d;
         lat_q <= lat_d;
      end
   end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
   parameter int W = 8
) (
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] lat_q,
   output logic [W-1:0] oe,
   output logic [W-1:0] val,
   output logic [W-1:0] pu
);
   for (genvar n = 0; n < W; n++) begin : g_pin
      always_comb begin
         oe[n]  = dir_q[n];
         val[n] = lat_q[n];
         pu[n]  = lat_q[n] & ~dir_q[n];
      end
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_pkg::*;
#(
   parameter int PIN_W       = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int OFS_PIN     = 0,
   parameter int OFS_DIR     = 1,
   parameter int OFS_LAT     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [PIN_W-1:0]  bus_wdata,
   output logic [PIN_W-1:0]  bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pad_oe,
   output logic [PIN_W-1:0]  pad_out,
   output logic [PIN_W-1:0]  pad_pu
);
   localparam int SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(OFS_PIN);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_LAT = ADDR_W'(OFS_LAT);

   if (PIN_W < 1) begin : g_bad_width
      $error("gpio_port_ctrl: PIN_W must be positive");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("gpio_port_ctrl: ADDR_W must cover three registers");
   end
   if (OFS_PIN >= SPAN || OFS_DIR >= SPAN || OFS_LAT >= SPAN) begin : g_bad_ofs
      $error("gpio_port_ctrl: register offset outside address span");
   end
   if (OFS_PIN == OFS_DIR || OFS_PIN == OFS_LAT || OFS_DIR == OFS_LAT) begin : g_dup_ofs
      $error("gpio_port_ctrl: register offsets must be distinct");
   end

   reg_sel_e          sel;
   logic [PIN_W-1:0]  dir_q, lat_q, pin_s;

   always_comb begin
      if      (bus_addr == A_PIN) sel = SEL_PIN;
      else if (bus_addr == A_DIR) sel = SEL_DIR;
      else if (bus_addr == A_LAT) sel = SEL_LAT;
      else                        sel = SEL_NONE;
   end

   gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (pin_s)
   );

   gpio_regs #(.W(PIN_W)) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .wr    (bus_wr),
      .wdata (bus_wdata),
      .dir_q (dir_q),
      .lat_q (lat_q)
   );

   gpio_pad_ctl #(.W(PIN_W)) pad_i (
      .dir_q (dir_q),
      .lat_q (lat_q),
      .oe    (pad_oe),
      .val   (pad_out),
      .pu    (pad_pu)
   );

   always_comb begin
      unique case (sel)
         SEL_PIN:  bus_rdata = pin_s;
         SEL_DIR:  bus_rdata = dir_q;
         SEL_LAT:  bus_rdata = lat_q;
         SEL_NONE: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
   parameter int PIN_W  = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [PIN_W-1:0]  bus_wdata,
   input logic [PIN_W-1:0]  bus_rdata,
   input logic [PIN_W-1:0]  pad_oe,
   input logic [PIN_W-1:0]  pad_out,
   input logic [PIN_W-1:0]  pad_pu
);
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_clear: assert (pad_oe == '0 && pad_out == '0 && pad_pu == '0)
            else $error("R1 pads not cleared in reset");
      end
   end

   a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd1) |=> (pad_oe == $past(bus_wdata)));

   a_r3_lat_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd2) |=> (pad_out == $past(bus_wdata)));

   a_r3_lat_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd2) |-> (bus_rdata == pad_out));

   a_r5_no_pu_on_output: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_oe) == '0));

   a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0) |=>
         (pad_out == ($past(pad_out) ^ $past(bus_wdata))) && $stable(pad_oe));

   a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3) |=> ($stable(pad_oe) && $stable(pad_out)));

   a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .pad_pu    (pad_pu)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   bus_addr = '0;
   logic         bus_wr = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pad_oe, pad_out, pad_pu;

   int vectors = 0;
   int misses = 0;
   bit finished = 1'b0;

   // reference model state
   logic [W-1:0] m_dir = '0;
   logic [W-1:0] m_lat = '0;
   logic [W-1:0] hist[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] pin_view();
      if (hist.size() >= 2) return hist[hist.size()-2];
      return '0;
   endfunction

   // one bus cycle: drive after negedge, compare, then advance model at posedge
   task automatic cyc(bit wr, logic [1:0] a, logic [W-1:0] wd, logic [W-1:0] pins);
      logic [W-1:0] exp_rd, n_dir, n_lat;
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = wd; pin_in = pins;
      #1;
      case (a)
         2'd0: exp_rd = pin_view();
         2'd1: exp_rd = m_dir;
         2'd2: exp_rd = m_lat;
         default: exp_rd = '0;
      endcase
      case (a)
         2'd0: check("R7 pin read", bus_rdata, exp_rd);
         2'd1: check("R2 dir read", bus_rdata, exp_rd);
         2'd2: check("R3 latch read", bus_rdata, exp_rd);
         default: check("R8 unmapped read", bus_rdata, exp_rd);
      endcase
      check("R2 pad_oe", pad_oe, m_dir);
      check("R4 R6 pad_out", pad_out, m_lat);
      check("R5 pad_pu", pad_pu, ~m_dir & m_lat);
      n_dir = m_dir; n_lat = m_lat;
      if (wr) begin
         if (a == 2'd1) n_dir = wd;
         else if (a == 2'd2) n_lat = wd;
         else if (a == 2'd0) n_lat = m_lat ^ wd;
      end
      @(posedge clk);
      m_dir = n_dir; m_lat = n_lat;
      hist.push_back(pins);
      if (hist.size() > 4) void'(hist.pop_front());
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         misses++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] dsnap, lsnap;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 pad_oe in reset", pad_oe, '0);
      check("R1 pad_pu in reset", pad_pu, '0);
      bus_addr = 2'd1; #1 check("R1 dir read in reset", bus_rdata, '0);
      bus_addr = 2'd2; #1 check("R1 latch read in reset", bus_rdata, '0);
      rst_n = 1'b1;
      hist.delete();

      // directed
      cyc(0, 2'd0, 8'h00, 8'hC3);   // R7: before two edges reads zero
      cyc(0, 2'd0, 8'h00, 8'hC3);
      cyc(0, 2'd0, 8'h00, 8'h3C);   // R7: now shows C3
      cyc(1, 2'd1, 8'hF0, 8'h3C);   // R2
      cyc(1, 2'd2, 8'hAA, 8'h3C);   // R3, R5 mix
      cyc(0, 2'd2, 8'h00, 8'h3C);
      cyc(1, 2'd0, 8'h0F, 8'h5A);   // R6 toggle
      cyc(0, 2'd2, 8'h00, 8'h5A);
      cyc(1, 2'd0, 8'h00, 8'h5A);   // R6 zero toggle
      cyc(0, 2'd1, 8'h00, 8'h5A);
      dsnap = m_dir; lsnap = m_lat;
      cyc(1, 2'd3, 8'hFF, 8'hFF);   // R8 write ignored
      cyc(0, 2'd1, 8'h00, 8'hFF);
      check("R8 dir after unmapped write", pad_oe, dsnap);
      cyc(0, 2'd2, 8'h00, 8'hFF);
      check("R8 latch after unmapped write", pad_out, lsnap);
      cyc(1, 2'd1, 8'hFF, 8'h00);   // all outputs: R5 no pull-ups
      cyc(1, 2'd1, 8'h00, 8'h00);   // all inputs: pull-ups follow latch
      cyc(0, 2'd0, 8'h00, 8'h00);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         cyc(1'($urandom), 2'($urandom), W'($urandom), W'($urandom));
      end

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule